// File: doc/BRIEF.md
# Sequential Booth/Shift-Add Multiplier

This block multiplies two 16-bit operands into a 32-bit product, one source bit per step, in either unsigned or two's-complement mode. A caller places the operands and the mode on the inputs and raises `start_i` for one cycle while the block is idle. The block then raises `busy_o`, walks across the scanned operand from the least significant bit upward, and ends by pulsing `done_o` for one cycle. At that point `product_o`, the zero and negative indications, and a count of the cycles the operation took are all valid.

The latency depends on the data, so the block models a processor multiply unit whose timing varies with the bit pattern. In unsigned mode each set bit of the scanned operand costs an addition. In signed mode the scanned operand is extended with a zero below its LSB. Each adjacent pair of bits in that extended value is recoded: a 1 above a 0 subtracts the shifted multiplicand, a 0 above a 1 adds it, and equal bits do nothing. Each add or subtract event costs two extra cycles. Idle padding fills the fixed part, so the total is always a base of 38 clocks plus two per event.

Top module: `smul_top`

## Requirements
- R1: In unsigned mode (`signed_i`=0), `product_o` equals the 32-bit unsigned product of `op_a_i` and `op_src_i`.
- R2: In signed mode (`signed_i`=1), `product_o` equals the 32-bit two's-complement product of the two operands, each read as a signed 16-bit value.
- R3: In unsigned mode, the number of clock edges from the edge that accepts `start_i` to the edge that raises `done_o` is 38 + 2n, where n is the count of 1 bits in `op_src_i`.
- R4: In signed mode, that latency is 38 + 2n, where n is the count of adjacent unequal bit pairs in the 17-bit value {`op_src_i`, 0`}. Source 0x5555 gives n=16 and 70 clocks; 0xAAAA gives 68.
- R5: `busy_o` is high from the edge after the start is accepted until the edge that raises `done_o`. `busy_o` is low while `done_o` is high, and `done_o` stays high for exactly one cycle.
- R6: While `done_o` is high, `cycles_o` holds the latency defined in R3 and R4 for the operation just finished.
- R7: While `done_o` is high, `zero_o` is 1 exactly when `product_o` is all zeros, and `neg_o` equals bit 31 of `product_o`.
- R8: A `start_i` pulse while `busy_o` is high is ignored. The running operation's product and latency are unchanged, and no second operation follows.
- R9: After reset, `busy_o`, `done_o`, `product_o`, `zero_o`, `neg_o` and `cycles_o` are all zero.
- R10: `product_o`, the flags and `cycles_o` keep their values after `done_o` until the next operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an operation (taken only when idle) |
| signed_i | input | 1 | 1 = two's-complement mode, 0 = unsigned |
| op_a_i | input | 16 | Multiplicand |
| op_src_i | input | 16 | Scanned operand that sets the latency |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| product_o | output | 32 | Product |
| zero_o | output | 1 | Product is zero |
| neg_o | output | 1 | Product bit 31 |
| cycles_o | output | 7 | Latency of the last operation in clocks |

## Verification
The bench checks the unsigned and signed modes against arithmetic products and against the latency formula. It uses a grid of corner operands and a long pseudo-random sweep. A recoder with its add and subtract swapped would give negated signed products. A recoder that drops the appended zero below the LSB would miss the first event for every odd source, so both the product and the count would be wrong. Source patterns 0x5555, 0xAAAA, 0x8000, 0x7FFF and 0xFFFF test the event counting at its extremes. A padding or event state that is one clock too long or too short would move `done_o` away from 38+2n. A start pulse in the middle of a run shows whether the block wrongly reloads its operands or queues a second run.

// File: rtl/smul_pkg.sv
package smul_pkg;
  typedef enum logic [1:0] {OP_NONE, OP_ADD, OP_SUB} rec_op_t;
  typedef enum logic [2:0] {ST_IDLE, ST_SCAN, ST_EV1, ST_EV2, ST_PAD} st_t;
endpackage

// File: rtl/smul_recode.sv
module smul_recode
  import smul_pkg::*;
(
  input  logic       signed_mode,
  input  logic [1:0] pair,   // [1] = current bit, [0] = bit below
  output rec_op_t    op
);
  always_comb begin
    if (!signed_mode) begin
      op = pair[1] ? OP_ADD : OP_NONE;
    end else begin
      unique case (pair)
        2'b10:   op = OP_SUB;
        2'b01:   op = OP_ADD;
        default: op = OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/smul_dp.sv
module smul_dp
  import smul_pkg::*;
#(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           step,
  input  logic           mode_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  rec_op_t        op,
  output logic [1:0]     pair,
  output logic           mode_q,
  output logic [2*W-1:0] acc
);
  localparam int PW = 2 * W;

  logic [PW-1:0] mc;
  logic [W:0]    scan;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      mc     <= '0;
      scan   <= '0;
      mode_q <= 1'b0;
    end else if (load) begin
      acc    <= '0;
      mc     <= mode_i ? {{W{a_i[W-1]}}, a_i} : {{W{1'b0}}, a_i};
      scan   <= {b_i, 1'b0};
      mode_q <= mode_i;
    end else if (step) begin
      unique case (op)
        OP_ADD:  acc <= acc + mc;
        OP_SUB:  acc <= acc - mc;
        default: acc <= acc;
      endcase
      mc   <= mc << 1;
      scan <= scan >> 1;
    end
  end

  assign pair = scan[1:0];
endmodule

// File: rtl/smul_ctrl.sv
module smul_ctrl
  import smul_pkg::*;
#(
  parameter int W    = 16,
  parameter int BASE = 38,
  parameter int CW   = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          active,
  output logic          load_o,
  output logic          step_o,
  output logic          finish_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [CW-1:0] cycles_o
);
  localparam int PADN = BASE - W;
  localparam int IW   = $clog2(W + 1);
  localparam int PDW  = $clog2(PADN + 1);

  st_t           st;
  logic [IW-1:0] idx;
  logic [PDW-1:0] pad;
  logic [CW-1:0] cyc;

  assign load_o   = (st == ST_IDLE) && start_i;
  assign step_o   = (st == ST_SCAN);
  assign finish_o = (st == ST_PAD) && (pad == PDW'(PADN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      idx      <= '0;
      pad      <= '0;
      cyc      <= '0;
      busy_o   <= 1'b0;
      done_o   <= 1'b0;
      cycles_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (st != ST_IDLE) cyc <= cyc + 1'b1;
      unique case (st)
        ST_IDLE: if (start_i) begin
          st     <= ST_SCAN;
          idx    <= '0;
          pad    <= '0;
          cyc    <= '0;
          busy_o <= 1'b1;
        end
        ST_SCAN: begin
          idx <= idx + 1'b1;
          if (active)                    st <= ST_EV1;
          else if (idx == IW'(W - 1))    st <= ST_PAD;
        end
        ST_EV1: st <= ST_EV2;
        ST_EV2: st <= (idx == IW'(W)) ? ST_PAD : ST_SCAN;
        ST_PAD: begin
          pad <= pad + 1'b1;
          if (finish_o) begin
            st       <= ST_IDLE;
            busy_o   <= 1'b0;
            done_o   <= 1'b1;
            cycles_o <= cyc + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/smul_top.sv
module smul_top
  import smul_pkg::*;
#(
  parameter int W    = 16,
  parameter int BASE = 38,
  parameter int CW   = $clog2(BASE + 2 * W + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_i,
  input  logic           signed_i,
  input  logic [W-1:0]   op_a_i,
  input  logic [W-1:0]   op_src_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [2*W-1:0] product_o,
  output logic           zero_o,
  output logic           neg_o,
  output logic [CW-1:0]  cycles_o
);
  logic           load, step, finish, mode_q;
  logic [1:0]     pair;
  logic [2*W-1:0] acc;
  rec_op_t        op;

  smul_recode u_rec (
    .signed_mode(mode_q),
    .pair       (pair),
    .op         (op)
  );

  smul_dp #(.W(W)) u_dp (
    .clk   (clk),
    .rst   (rst),
    .load  (load),
    .step  (step),
    .mode_i(signed_i),
    .a_i   (op_a_i),
    .b_i   (op_src_i),
    .op    (op),
    .pair  (pair),
    .mode_q(mode_q),
    .acc   (acc)
  );

  smul_ctrl #(.W(W), .BASE(BASE), .CW(CW)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .active  (op != OP_NONE),
    .load_o  (load),
    .step_o  (step),
    .finish_o(finish),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .cycles_o(cycles_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      product_o <= '0;
      zero_o    <= 1'b0;
      neg_o     <= 1'b0;
    end else if (finish) begin
      product_o <= acc;
      zero_o    <= (acc == '0);
      neg_o     <= acc[2*W-1];
    end
  end
endmodule

// File: rtl/smul_chk.sv
module smul_chk #(
  parameter int W    = 16,
  parameter int BASE = 38,
  parameter int CW   = 7
) (
  input logic           clk,
  input logic           rst,
  input logic           start_i,
  input logic           busy_o,
  input logic           done_o,
  input logic [2*W-1:0] product_o,
  input logic           zero_o,
  input logic           neg_o,
  input logic [CW-1:0]  cycles_o
);
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R5
  done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);
  // R5
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o);
  // R8
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o);
  // R6
  lat_range_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (int'(cycles_o) >= BASE && int'(cycles_o) <= BASE + 2 * W
                && cycles_o[0] == BASE[0]));
  // R7
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (zero_o == (product_o == '0)));
  // R7
  neg_flag_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (neg_o == product_o[2*W-1]));
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(product_o) && $stable(cycles_o)));
endmodule

bind smul_top smul_chk #(.W(W), .BASE(BASE), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
  .product_o(product_o), .zero_o(zero_o), .neg_o(neg_o), .cycles_o(cycles_o)
);

// File: tb/tb_smul_top.sv
module tb_smul_top;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 16;
  localparam int BASE = 38;
  localparam int CW = $clog2(BASE + 2 * W + 1);

  logic clk = 1'b0, rst = 1'b1, start_i = 1'b0, signed_i = 1'b0;
  logic [W-1:0] op_a_i = '0, op_src_i = '0;
  logic busy_o, done_o, zero_o, neg_o;
  logic [2*W-1:0] product_o;
  logic [CW-1:0] cycles_o;
  int total = 0, bad = 0;
  logic [31:0] rng = 32'h1ace_b00c;

  smul_top dut (.*);

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int n_events(input logic [W-1:0] b, input bit s);
    logic [W:0] e;
    int n = 0;
    e = {b, 1'b0};
    for (int i = 0; i < W; i++)
      if (s ? (e[i+1] != e[i]) : b[i]) n++;
    return n;
  endfunction

  function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, b, input bit s);
    logic signed [2*W-1:0] sa, sb;
    if (!s) return {{W{1'b0}}, a} * {{W{1'b0}}, b};
    sa = {{W{a[W-1]}}, a};
    sb = {{W{b[W-1]}}, b};
    return sa * sb;
  endfunction

  // Run one operation; optionally pulse start with other operands mid-run (R8).
  task automatic run(input logic [W-1:0] a, b, input bit s, input bit poke);
    int cnt = 0;
    logic [2*W-1:0] exp_p;
    int exp_l;
    exp_p = ref_mul(a, b, s);
    exp_l = BASE + 2 * n_events(b, s);
    @(negedge clk);
    op_a_i = a; op_src_i = b; signed_i = s; start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    op_a_i = ~a; op_src_i = ~b; signed_i = ~s;
    forever begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
      if (poke && cnt == 5) start_i = 1'b1;
      if (poke && cnt == 6) start_i = 1'b0;
      if (done_o || cnt > 200) break;
      if (!busy_o) begin
        chk(1'b0, "R5 busy during run", 64'(busy_o), 64'd1);
        break;
      end
    end
    start_i = 1'b0;
    if (s) chk(product_o == exp_p, "R2 signed product", 64'(product_o), 64'(exp_p));
    else   chk(product_o == exp_p, "R1 unsigned product", 64'(product_o), 64'(exp_p));
    if (s) chk(cnt == exp_l, "R4 signed latency", 64'(cnt), 64'(exp_l));
    else   chk(cnt == exp_l, "R3 unsigned latency", 64'(cnt), 64'(exp_l));
    chk(int'(cycles_o) == exp_l, "R6 cycles_o", 64'(cycles_o), 64'(exp_l));
    chk(zero_o == (exp_p == '0), "R7 zero flag", 64'(zero_o), 64'(exp_p == '0));
    chk(neg_o == exp_p[2*W-1], "R7 neg flag", 64'(neg_o), 64'(exp_p[2*W-1]));
    chk(!busy_o, "R5 busy low at done", 64'(busy_o), 64'd0);
    @(negedge clk);
    chk(!done_o, "R5 done one cycle", 64'(done_o), 64'd0);
    chk(product_o == exp_p, "R10 product held", 64'(product_o), 64'(exp_p));
    if (poke) chk(!busy_o, "R8 no second run", 64'(busy_o), 64'd0);
  endtask

  initial begin
    logic [W-1:0] corners [12];
    logic [W-1:0] avals [6];
    corners = '{16'h0000, 16'h0001, 16'hFFFF, 16'h5555, 16'hAAAA, 16'h8000,
                16'h7FFF, 16'h8001, 16'h00FF, 16'hFF00, 16'h1234, 16'h0F0F};
    avals   = '{16'h0000, 16'h0001, 16'hFFFF, 16'h8000, 16'h7FFF, 16'hBEEF};
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    chk(!busy_o && !done_o, "R9 reset control", 64'({busy_o, done_o}), 64'd0);
    chk(product_o == '0 && !zero_o && !neg_o, "R9 reset data", 64'(product_o), 64'd0);
    chk(cycles_o == '0, "R9 reset cycles", 64'(cycles_o), 64'd0);
    // Extremes of event counting: R4 worst case 0x5555 -> 70
    run(16'h0003, 16'h5555, 1'b1, 1'b0);
    chk(int'(cycles_o) == 70, "R4 worst case 70", 64'(cycles_o), 64'd70);
    run(16'h0003, 16'hAAAA, 1'b1, 1'b0);
    chk(int'(cycles_o) == 68, "R4 0xAAAA gives 68", 64'(cycles_o), 64'd68);
    // R8 start during busy
    run(16'h1357, 16'h2468, 1'b0, 1'b1);
    run(16'h9abc, 16'h5555, 1'b1, 1'b1);
    // corner grid, both modes
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 12; i++)
        for (int j = 0; j < 6; j++)
          run(avals[j], corners[i], s[0], 1'b0);
    // walking single bits
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < W; i++)
        run(16'hA5C3, 16'(1 << i), s[0], 1'b0);
    // pseudo-random sweep
    for (int k = 0; k < 1200; k++) begin
      rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
      run(rng[15:0], rng[31:16], rng[3], 1'b0);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    total++;
    bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule